// File: doc/BRIEF.md
# Programmable UART baud generator

This block derives the timing strobes of an asynchronous serial channel from the peripheral clock. The clock first passes a prescaler whose ratio is picked by a 2-bit source select. The select values give ratios of 1, 4, 16 or 64, and the prescaler also includes a fixed pre-divide by two. The prescaled ticks then step an 8-bit reloadable divisor counter. Each terminal count of that counter gives a one-cycle 16x-oversampling strobe. Every sixteenth oversampling strobe also gives a one-cycle bit-period strobe, so one bit lasts 32·4^n·(N+1) clocks. Here n is the source select and N is the divisor value.

The host reaches the divisor and the source select through a small register port. Writes are strobed and reads are combinational. Any write restarts every counter, so a new rate begins with a whole period. A standby input does three things while it is asserted: it forces the divisor back to all-ones, it holds the counters cleared, and it silences both strobes. Every instance keeps its own settings, so two channels can run at unrelated rates.

Top module: `baud_gen`

## Requirements
- R1: After reset the divisor reads 0xFF, the source select reads 0, and neither strobe is active.
- R2: With bus_addr_i at 0 the divisor is written and read as a full 8-bit value. With bus_addr_i at 1 the source select is written from data bits [1:0], and it reads back in bits [1:0] with bits [7:2] returning zero. A write needs bus_sel_i and bus_wr_i both high.
- R3: Source select codes 0, 1, 2 and 3 give prescale ratios of 1, 4, 16 and 64. These follow a fixed pre-divide by 2, so one prescaled tick lasts P = 2·4^n clocks.
- R4: ovs_tick_o is a one-cycle pulse repeating every P·(N+1) clocks.
- R5: bit_tick_o is high only together with ovs_tick_o, on every 16th oversampling pulse, so it repeats every 16·P·(N+1) clocks.
- R6: A write clears all counters. No strobe appears in the cycle after the capturing edge. The first ovs_tick_o is seen P·(N+1)+1 cycles after that edge, and the first bit_tick_o is seen 16·P·(N+1)+1 cycles after it.
- R7: While standby_i is high the divisor becomes and stays 0xFF, and host writes to it have no effect. The source select keeps its value.
- R8: While standby_i is high no strobe is produced. After standby_i falls, the first ovs_tick_o is seen after P·(N+1)−1 rising edges.
- R9: Two instances run independently. Standby of one does not disturb the other's strobe rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| standby_i | input | 1 | Standby request: forces divisor to 0xFF and halts strobes |
| bus_sel_i | input | 1 | Register port select |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 = divisor, 1 = source select |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| ovs_tick_o | output | 1 | 16x oversampling strobe |
| bit_tick_o | output | 1 | Bit-period strobe |

## Verification
The checker watches several rules on every cycle. Both strobes stay silent while standby is high, and the divisor reads all-ones in the cycle after standby. No strobe appears in the cycle after a write. The bit strobe never appears without the oversampling strobe, and no two oversampling strobes fall on adjacent cycles. The upper select bits always read zero. The exact spacing of the strobes for each source select and divisor value, including the delays after a write and after standby, can only be shown by the bench sweeps: these count cycles against 2·4^n·(N+1) and its sixteenfold multiple. The bench also shows that a second channel keeps its rate.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // register port address map
  typedef enum logic {
    REG_DIV = 1'b0,
    REG_SEL = 1'b1
  } baud_reg_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                standby_i,
  input  logic                wr_en_i,
  input  baud_pkg::baud_reg_e addr_i,
  input  logic [DIV_W-1:0]    wdata_i,
  output logic [DIV_W-1:0]    div_q,
  output logic [SEL_W-1:0]    sel_q,
  output logic                cfg_chg_q
);
  logic [DIV_W-1:0] div_d;
  logic [SEL_W-1:0] sel_d;
  logic             chg_d;

  always_comb begin
    div_d = div_q;
    sel_d = sel_q;
    chg_d = 1'b0;
    if (wr_en_i) begin
      chg_d = 1'b1;
      if (addr_i == baud_pkg::REG_DIV) begin
        div_d = wdata_i;
      end else begin
        sel_d = wdata_i[SEL_W-1:0];
      end
    end
    // standby overrides any host write to the divisor
    if (standby_i) begin
      div_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '1;
      sel_q     <= '0;
      cfg_chg_q <= 1'b0;
    end else begin
      div_q     <= div_d;
      sel_q     <= sel_d;
      cfg_chg_q <= chg_d;
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SEL_W    = 2,
  parameter int BASE_DIV = 2,
  parameter int PRE_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int N_SRC = 1 << SEL_W;

  logic [PRE_W-1:0] lim_tab [N_SRC];
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic             at_lim;

  // one terminal value per source select: BASE_DIV * 4^g - 1
  for (genvar g = 0; g < N_SRC; g++) begin : g_lim
    assign lim_tab[g] = PRE_W'((BASE_DIV << (2 * g)) - 1);
  end

  assign at_lim = (cnt_q == lim_tab[sel_i]);
  assign tick_o = at_lim & ~clr_i;

  always_comb begin
    if (clr_i || at_lim) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ovs_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign ovs_o   = step_i & at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = div_i;
    end else if (step_i) begin
      cnt_d = at_zero ? div_i : cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/baud_bitcnt.sv
module baud_bitcnt #(
  parameter int OVS_RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic ovs_i,
  output logic bit_o
);
  localparam int BIT_W = $clog2(OVS_RATIO);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(OVS_RATIO - 1);

  logic [BIT_W-1:0] cnt_q;
  logic [BIT_W-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign bit_o   = ovs_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (ovs_i) begin
      cnt_d = at_last ? '0 : cnt_q + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int DIV_W     = 8,
  parameter int SEL_W     = 2,
  parameter int BASE_DIV  = 2,
  parameter int OVS_RATIO = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic             bus_sel_i,
  input  logic             bus_wr_i,
  input  logic             bus_addr_i,
  input  logic [DIV_W-1:0] bus_wdata_i,
  output logic [DIV_W-1:0] bus_rdata_o,
  output logic             ovs_tick_o,
  output logic             bit_tick_o
);
  localparam int PRE_W = $clog2(BASE_DIV * (4 ** ((1 << SEL_W) - 1)));

  baud_pkg::baud_reg_e addr;
  logic [DIV_W-1:0]    div_q;
  logic [SEL_W-1:0]    sel_q;
  logic                cfg_chg_q;
  logic                wr_en;
  logic                clr;
  logic                pre_tick;
  logic                ovs;
  logic                bit_tick;

  assign addr  = baud_pkg::baud_reg_e'(bus_addr_i);
  assign wr_en = bus_sel_i & bus_wr_i;
  assign clr   = standby_i | cfg_chg_q;

  baud_regs #(
    .DIV_W(DIV_W),
    .SEL_W(SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (bus_wdata_i),
    .div_q     (div_q),
    .sel_q     (sel_q),
    .cfg_chg_q (cfg_chg_q)
  );

  baud_prescaler #(
    .SEL_W   (SEL_W),
    .BASE_DIV(BASE_DIV),
    .PRE_W   (PRE_W)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .sel_i  (sel_q),
    .tick_o (pre_tick)
  );

  baud_divider #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .step_i (pre_tick),
    .div_i  (div_q),
    .ovs_o  (ovs)
  );

  baud_bitcnt #(
    .OVS_RATIO(OVS_RATIO)
  ) u_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .ovs_i (ovs),
    .bit_o (bit_tick)
  );

  always_comb begin
    if (addr == baud_pkg::REG_SEL) begin
      bus_rdata_o = DIV_W'(sel_q);
    end else begin
      bus_rdata_o = div_q;
    end
  end

  assign ovs_tick_o = ovs;
  assign bit_tick_o = bit_tick;
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby_i,
  input logic             bus_sel_i,
  input logic             bus_wr_i,
  input logic             bus_addr_i,
  input logic [DIV_W-1:0] bus_rdata_o,
  input logic             ovs_tick_o,
  input logic             bit_tick_o
);
  // R2: select readback has zero upper bits
  p_sel_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_i |-> (bus_rdata_o[DIV_W-1:SEL_W] == '0));

  // R4: oversampling strobe lasts a single cycle
  p_ovs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovs_tick_o |=> !ovs_tick_o);

  // R5: bit strobe only together with oversampling strobe
  p_bit_on_ovs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |-> ovs_tick_o);

  // R6: the cycle after a captured write carries no strobe
  p_write_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_wr_i) |=> (!ovs_tick_o && !bit_tick_o));

  // R7: divisor reads all-ones in the cycle after standby
  p_standby_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (bus_addr_i || (bus_rdata_o == '1)));

  // R8: standby silences both strobes
  p_standby_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |-> (!ovs_tick_o && !bit_tick_o));
endmodule

bind baud_gen baud_gen_chk #(
  .DIV_W(DIV_W),
  .SEL_W(SEL_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .standby_i   (standby_i),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .ovs_tick_o  (ovs_tick_o),
  .bit_tick_o  (bit_tick_o)
);

// File: tb/test_baud_gen.sv
`timescale 1ns/1ps
module test_baud_gen;
  logic       clk;
  logic       rst_n;
  logic       standby;
  logic       bsel;
  logic       bwr;
  logic       baddr;
  logic [7:0] bwdata;
  logic [7:0] brdata;
  logic       ovs;
  logic       bit_t;

  logic       bsel_b;
  logic       bwr_b;
  logic [7:0] bwdata_b;
  logic [7:0] brdata_b;
  logic       ovs_b;
  logic       bit_b;

  int n_checks;
  int n_fail;
  bit done;

  baud_gen i_baud_gen (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .bus_sel_i(bsel),
    .bus_wr_i(bwr), .bus_addr_i(baddr), .bus_wdata_i(bwdata),
    .bus_rdata_o(brdata), .ovs_tick_o(ovs), .bit_tick_o(bit_t)
  );

  baud_gen i_baud_gen_b (
    .clk(clk), .rst_n(rst_n), .standby_i(1'b0), .bus_sel_i(bsel_b),
    .bus_wr_i(bwr_b), .bus_addr_i(1'b0), .bus_wdata_i(bwdata_b),
    .bus_rdata_o(brdata_b), .ovs_tick_o(ovs_b), .bit_tick_o(bit_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, captured by the next rising edge;
  // returns at the falling edge of the clear cycle (k = 1)
  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bsel = 1'b1; bwr = 1'b1; baddr = a; bwdata = d;
    @(negedge clk);
    bsel = 1'b0; bwr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    baddr = a;
    #1;
    d = brdata;
  endtask

  task automatic sweep_one(input int n, input int nv);
    int per, first_exp, bit_exp, lim;
    int first_ovs, second_ovs, first_bit, ovs_cnt;
    bit chk_bit;
    per       = (2 << (2 * n)) * (nv + 1);
    first_exp = per + 1;
    bit_exp   = 16 * per + 1;
    chk_bit   = (16 * per <= 8192);
    lim       = chk_bit ? bit_exp : first_exp;
    bus_write(1'b1, 8'(n));
    bus_write(1'b0, 8'(nv));
    check(!ovs, "R6 no strobe in clear cycle", int'(ovs), 0);
    first_ovs = 0; second_ovs = 0; first_bit = 0; ovs_cnt = 0;
    for (int k = 2; k <= lim; k++) begin
      @(negedge clk);
      if (ovs) begin
        ovs_cnt++;
        if (first_ovs == 0) first_ovs = k;
        else if (second_ovs == 0) second_ovs = k;
      end
      if (bit_t && first_bit == 0) first_bit = k;
    end
    // R3 / R6: first oversample strobe after the write
    check(first_ovs == first_exp, $sformatf("R3 R6 first ovs sel=%0d N=%0d", n, nv),
          first_ovs, first_exp);
    if (chk_bit) begin
      check(second_ovs == first_exp + per, $sformatf("R4 ovs spacing sel=%0d N=%0d", n, nv),
            second_ovs - first_ovs, per);
      check(first_bit == bit_exp, $sformatf("R5 first bit sel=%0d N=%0d", n, nv),
            first_bit, bit_exp);
      check(ovs_cnt == 16, $sformatf("R5 ovs per bit sel=%0d N=%0d", n, nv), ovs_cnt, 16);
    end
  endtask

  initial begin
    logic [7:0] rd;
    int cnt_a, cnt_b, first_j;
    int nv_tab [4];
    n_checks = 0; n_fail = 0; done = 1'b0;
    nv_tab[0] = 0; nv_tab[1] = 1; nv_tab[2] = 8'h7F; nv_tab[3] = 8'hFF;
    rst_n = 1'b0; standby = 1'b0; bsel = 1'b0; bwr = 1'b0; baddr = 1'b0; bwdata = '0;
    bsel_b = 1'b0; bwr_b = 1'b0; bwdata_b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_read(1'b0, rd);
    check(rd == 8'hFF, "R1 divisor reset", int'(rd), 255);
    bus_read(1'b1, rd);
    check(rd == 8'h00, "R1 select reset", int'(rd), 0);
    check(!ovs && !bit_t, "R1 no strobes", int'({ovs, bit_t}), 0);

    // channel b: select 0, divisor 0 -> ovs every 2 cycles
    @(negedge clk);
    bsel_b = 1'b1; bwr_b = 1'b1; bwdata_b = 8'h00;
    @(negedge clk);
    bsel_b = 1'b0; bwr_b = 1'b0;

    // R2: register access
    bus_write(1'b0, 8'h5A);
    bus_read(1'b0, rd);
    check(rd == 8'h5A, "R2 divisor readback", int'(rd), 90);
    bus_write(1'b1, 8'hFE);
    bus_read(1'b1, rd);
    check(rd == 8'h02, "R2 select masked", int'(rd), 2);
    @(negedge clk);
    bsel = 1'b0; bwr = 1'b1; baddr = 1'b0; bwdata = 8'h11;
    @(negedge clk);
    bwr = 1'b0;
    bus_read(1'b0, rd);
    check(rd == 8'h5A, "R2 write without select ignored", int'(rd), 90);

    // R3 R4 R5 R6: sweep of all selects and boundary divisors
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 4; i++) begin
        sweep_one(n, nv_tab[i]);
      end
    end

    // R7 R8 R9: standby behaviour
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h10);
    @(negedge clk);
    standby = 1'b1;
    bus_write(1'b0, 8'h33);
    cnt_a = 0; cnt_b = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (ovs || bit_t) cnt_a++;
      if (ovs_b) cnt_b++;
    end
    check(cnt_a == 0, "R8 no strobes in standby", cnt_a, 0);
    check(cnt_b == 50, "R9 other channel keeps rate", cnt_b, 50);
    bus_read(1'b0, rd);
    check(rd == 8'hFF, "R7 divisor forced and write ignored", int'(rd), 255);
    bus_read(1'b1, rd);
    check(rd == 8'h00, "R7 select kept", int'(rd), 0);
    @(negedge clk);
    standby = 1'b0;
    first_j = 0;
    for (int j = 1; j <= 520; j++) begin
      @(negedge clk);
      if (ovs && first_j == 0) first_j = j;
    end
    check(first_j == 511, "R8 first ovs after standby", first_j, 511);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule